// File: doc/BRIEF.md
# Dual-Bank Switch State Register File

This block keeps the open/closed state of two banks of sixteen analog switches, called bank A and bank B, and drives that state onto two 16-bit output vectors. A byte-wide register port is shared by whichever serial front end sits upstream. It writes directly into the live switch registers or into a set of staging (shadow) registers. It also accepts a two-byte command that acts on both banks at once. The command can close exactly one switch, open a whole bank, copy the staged state into the bank, or leave the bank alone. A separate 32-bit bulk port replaces the whole switch state in a single cycle. The shift-register front end uses it once a full frame has arrived.

Both input ports use a valid/ready handshake. Each `*_ready` output is held high, so the block never applies back-pressure. A transfer happens at each rising clock edge where the matching `*_valid` is high. A byte write that coincides with a bulk transfer is dropped completely. Reads are combinational: `rd_data` follows `rd_addr` in the same cycle. The active-low shutdown input clears every register and blocks all writes for as long as it is held low.

Top module: `dual_bank_switch_regs`

## Requirements
- R1: A byte write to 0x00, 0x01, 0x02 or 0x03 sets switch state A[7:0], A[15:8], B[7:0] or B[15:8] respectively, with data bit 0 as the lowest-numbered switch and 1 meaning closed. The new value appears on `sw_a`/`sw_b` right after the accepting edge and reads back at the same address.
- R2: Byte writes to 0x10–0x13 fill the staging registers with the same layout as R1. They read back at their own address and leave `sw_a`/`sw_b` unchanged.
- R3: Command code n in 0–15, taken from data bits [4:0], closes only switch n of its bank (output bit n) and opens the other fifteen.
- R4: Command code 16 opens every switch of its bank.
- R5: Command code 17 loads the bank's switch state from its two staging registers.
- R6: Command codes 18–31 leave the bank unchanged. Data bits [7:5] of a command byte are ignored.
- R7: A write to 0x14 (bank A command) changes no output by itself. A later write to 0x15 (bank B command) applies the latched A code and the B code at the same edge. If 0x14 is written twice before that, the later code wins.
- R8: A write to 0x15 with no bank A command latched since the last execution leaves bank A unchanged. The latch clears at each execution.
- R9: Reads of 0x14, 0x15 and of any unmapped address return 0x00.
- R10: While `shdn_n` is low, all switch, staging and command state is cleared to zero, and byte and bulk writes have no effect.
- R11: A bulk transfer loads `sw_a` from `bulk_data[15:0]` and `sw_b` from `bulk_data[31:16]`. A byte write in the same cycle is discarded, including writes to staging registers.
- R12: After reset every register reads 0x00 and both switch vectors are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low shutdown; clears state, blocks writes |
| reg_valid | input | 1 | Byte write request |
| reg_ready | output | 1 | Byte write accept, always high |
| reg_addr | input | 8 | Byte write register address |
| reg_wdata | input | 8 | Byte write data |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| bulk_valid | input | 1 | Bulk load request |
| bulk_ready | output | 1 | Bulk load accept, always high |
| bulk_data | input | 32 | Bulk switch word, bank B in the upper half |
| sw_a | output | 16 | Bank A switch state, 1 = closed |
| sw_b | output | 16 | Bank B switch state, 1 = closed |

## Verification
The properties assume the port is only ever driven with single-beat requests: one byte address per cycle and no X on the valid lines after reset. They also treat a bulk transfer as overriding everything except shutdown. The stimulus drives every request for exactly one cycle, changing inputs at the falling edge, and holds valid low otherwise. The stimulus sweeps all 32 command codes on bank A, each paired with a distinct bank B code. It reloads the staging and live registers with fresh arithmetic patterns before every command pair, so copy, clear, one-hot and hold results can be told apart.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam logic [7:0] DIR_BASE   = 8'h00;
  localparam logic [7:0] SHD_BASE   = 8'h10;
  localparam logic [7:0] CMD_A_ADDR = 8'h14;
  localparam logic [7:0] CMD_B_ADDR = 8'h15;
  localparam int         NBANK      = 2;
endpackage

// File: rtl/swr_cmd_ctrl.sv
module swr_cmd_ctrl #(
  parameter int CODE_W = 5,
  parameter int NSW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [CODE_W-1:0] wcode,
  output logic              exec,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  localparam logic [CODE_W-1:0] HOLD_CODE = CODE_W'(NSW + 2);

  logic              pend;
  logic [CODE_W-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      lat  <= '0;
    end else if (!shdn_n) begin
      pend <= 1'b0;
      lat  <= '0;
    end else if (wr_b) begin
      pend <= 1'b0;
      lat  <= '0;
    end else if (wr_a) begin
      pend <= 1'b1;
      lat  <= wcode;
    end
  end

  assign exec   = wr_b;
  assign code_b = wcode;
  assign code_a = pend ? lat : HOLD_CODE;

  // R8: the bank A latch never survives an execution
  assert_latch_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !pend);
  // R7: a bank A command stays pending until the bank B byte arrives
  assert_a_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !wr_b && shdn_n) |=> (pend && lat == $past(wcode)));
endmodule

// File: rtl/swr_bank.sv
module swr_bank #(
  parameter int NSW    = 16,
  parameter int BW     = 8,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic [NSW/BW-1:0] dir_we,
  input  logic [NSW/BW-1:0] shd_we,
  input  logic [BW-1:0]     wdata,
  input  logic              bulk_we,
  input  logic [NSW-1:0]    bulk_word,
  input  logic              exec,
  input  logic [CODE_W-1:0] code,
  output logic [NSW-1:0]    dir,
  output logic [NSW-1:0]    shd
);
  localparam int NB = NSW / BW;
  localparam logic [CODE_W-1:0] CLR_CODE = CODE_W'(NSW);
  localparam logic [CODE_W-1:0] CPY_CODE = CODE_W'(NSW + 1);

  logic [NSW-1:0] cmd_next;

  always_comb begin
    cmd_next = dir;
    if (code < CLR_CODE)       cmd_next = NSW'(1) << code;
    else if (code == CLR_CODE) cmd_next = '0;
    else if (code == CPY_CODE) cmd_next = shd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir <= '0;
    end else if (!shdn_n) begin
      dir <= '0;
    end else if (bulk_we) begin
      dir <= bulk_word;
    end else if (exec) begin
      dir <= cmd_next;
    end else begin
      for (int i = 0; i < NB; i++)
        if (dir_we[i]) dir[i*BW +: BW] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_shd_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  shd[g*BW +: BW] <= '0;
        else if (!shdn_n)            shd[g*BW +: BW] <= '0;
        else if (shd_we[g] && !bulk_we) shd[g*BW +: BW] <= wdata;
      end
    end
  endgenerate

  // R3: one-hot command leaves exactly one switch closed
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && shdn_n && !bulk_we && code < CLR_CODE) |=> $countones(dir) == 1);
  // R4: clear command opens the bank
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && shdn_n && !bulk_we && code == CLR_CODE) |=> dir == '0);
  // R5: copy command takes the staging value of the previous cycle
  assert_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && shdn_n && !bulk_we && code == CPY_CODE) |=> dir == $past(shd));
  // R6: remaining codes hold the bank
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && shdn_n && !bulk_we && code > CPY_CODE) |=> $stable(dir));
  // R2: staging writes alone never move the switches
  assert_shadow_isolated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_n && !bulk_we && !exec && dir_we == '0) |=> $stable(dir));
  // R10: shutdown empties the bank
  assert_shutdown_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (dir == '0 && shd == '0));
  // R11: bulk load wins
  assert_bulk_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bulk_we && shdn_n) |=> dir == $past(bulk_word));
endmodule

// File: rtl/dual_bank_switch_regs.sv
module dual_bank_switch_regs
  import swr_pkg::*;
#(
  parameter int NSW = 16,
  parameter int BW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shdn_n,
  input  logic                 reg_valid,
  output logic                 reg_ready,
  input  logic [7:0]           reg_addr,
  input  logic [BW-1:0]        reg_wdata,
  input  logic [7:0]           rd_addr,
  output logic [BW-1:0]        rd_data,
  input  logic                 bulk_valid,
  output logic                 bulk_ready,
  input  logic [NBANK*NSW-1:0] bulk_data,
  output logic [NSW-1:0]       sw_a,
  output logic [NSW-1:0]       sw_b
);
  localparam int NB     = NSW / BW;
  localparam int CODE_W = $clog2(NSW + 2);

  logic              byte_go, bulk_go, exec;
  logic [CODE_W-1:0] code_a, code_b;
  logic [CODE_W-1:0] bank_code [NBANK];
  logic [NSW-1:0]    dir_v [NBANK];
  logic [NSW-1:0]    shd_v [NBANK];
  logic [NB-1:0]     dir_we [NBANK];
  logic [NB-1:0]     shd_we [NBANK];

  assign reg_ready  = 1'b1;
  assign bulk_ready = 1'b1;
  assign bulk_go    = bulk_valid && shdn_n;
  assign byte_go    = reg_valid && shdn_n && !bulk_valid;

  swr_cmd_ctrl #(.CODE_W(CODE_W), .NSW(NSW)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .shdn_n (shdn_n),
    .wr_a   (byte_go && reg_addr == CMD_A_ADDR),
    .wr_b   (byte_go && reg_addr == CMD_B_ADDR),
    .wcode  (reg_wdata[CODE_W-1:0]),
    .exec   (exec),
    .code_a (code_a),
    .code_b (code_b)
  );

  assign bank_code[0] = code_a;
  assign bank_code[1] = code_b;

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      for (genvar i = 0; i < NB; i++) begin : g_lane
        assign dir_we[b][i] = byte_go && reg_addr == 8'(int'(DIR_BASE) + b*NB + i);
        assign shd_we[b][i] = byte_go && reg_addr == 8'(int'(SHD_BASE) + b*NB + i);
      end
      swr_bank #(.NSW(NSW), .BW(BW), .CODE_W(CODE_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .shdn_n    (shdn_n),
        .dir_we    (dir_we[b]),
        .shd_we    (shd_we[b]),
        .wdata     (reg_wdata),
        .bulk_we   (bulk_go),
        .bulk_word (bulk_data[b*NSW +: NSW]),
        .exec      (exec),
        .code      (bank_code[b]),
        .dir       (dir_v[b]),
        .shd       (shd_v[b])
      );
    end
  endgenerate

  assign sw_a = dir_v[0];
  assign sw_b = dir_v[1];

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int i = 0; i < NB; i++) begin
        if (rd_addr == 8'(int'(DIR_BASE) + b*NB + i)) rd_data = dir_v[b][i*BW +: BW];
        if (rd_addr == 8'(int'(SHD_BASE) + b*NB + i)) rd_data = shd_v[b][i*BW +: BW];
      end
    end
  end

  // R7: latching the bank A command touches neither output
  assert_cmd_a_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_go && reg_addr == CMD_A_ADDR) |=> ($stable(sw_a) && $stable(sw_b)));
  // R10: outputs are zero one cycle into shutdown
  assert_shutdown_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> (sw_a == '0 && sw_b == '0));
endmodule

// File: tb/tb_dual_bank_switch_regs.sv
`timescale 1ns/1ps
module tb_dual_bank_switch_regs;
  logic        clk = 1'b0;
  logic        rst_n, shdn_n, reg_valid, reg_ready, bulk_valid, bulk_ready;
  logic [7:0]  reg_addr, reg_wdata, rd_addr, rd_data;
  logic [31:0] bulk_data;
  logic [15:0] sw_a, sw_b;

  always #2.5 clk = ~clk;

  dual_bank_switch_regs dut (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n),
    .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .bulk_valid(bulk_valid), .bulk_ready(bulk_ready), .bulk_data(bulk_data),
    .sw_a(sw_a), .sw_b(sw_b)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] ea, eb, sa, sb;
  logic        pa;
  logic [4:0]  la;

  function automatic logic [15:0] apply(logic [4:0] c, logic [15:0] cur, logic [15:0] s);
    if (c < 16)       return 16'(1) << c;
    else if (c == 16) return 16'h0000;
    else if (c == 17) return s;
    else              return cur;
  endfunction

  function automatic string cls(logic [4:0] c);
    if (c < 16)       return "R3";
    else if (c == 16) return "R4";
    else if (c == 17) return "R5";
    else              return "R6";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rd(string req, logic [7:0] a, logic [7:0] exp);
    rd_addr = a;
    #0.5;
    chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic raw_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    raw_wr(a, d);
    case (a)
      8'h00: ea[7:0]  = d;
      8'h01: ea[15:8] = d;
      8'h02: eb[7:0]  = d;
      8'h03: eb[15:8] = d;
      8'h10: sa[7:0]  = d;
      8'h11: sa[15:8] = d;
      8'h12: sb[7:0]  = d;
      8'h13: sb[15:8] = d;
      8'h14: begin pa = 1'b1; la = d[4:0]; end
      8'h15: begin
        ea = apply(pa ? la : 5'd31, ea, sa);
        eb = apply(d[4:0], eb, sb);
        pa = 1'b0;
      end
      default: ;
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shdn_n = 1'b1; reg_valid = 1'b0; bulk_valid = 1'b0;
    reg_addr = '0; reg_wdata = '0; rd_addr = '0; bulk_data = '0;
    ea = '0; eb = '0; sa = '0; sb = '0; pa = 1'b0; la = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 sw_a", sw_a, 0);
    chk("R12 sw_b", sw_b, 0);
    for (int a = 0; a < 4; a++) begin
      chk_rd("R12 direct", 8'(a), 8'h00);
      chk_rd("R12 staging", 8'(8'h10 + a), 8'h00);
    end

    // R1 direct byte writes
    for (int a = 0; a < 4; a++) begin
      wr(8'(a), 8'(8'h3C + a * 8'h51));
      chk("R1 sw_a", sw_a, ea);
      chk("R1 sw_b", sw_b, eb);
      chk_rd("R1 readback", 8'(a), 8'(8'h3C + a * 8'h51));
    end

    // R2 staging writes do not reach the switches
    for (int a = 0; a < 4; a++) begin
      wr(8'(8'h10 + a), 8'(8'hA5 ^ (a * 8'h1F)));
      chk("R2 sw_a", sw_a, ea);
      chk("R2 sw_b", sw_b, eb);
      chk_rd("R2 readback", 8'(8'h10 + a), 8'(8'hA5 ^ (a * 8'h1F)));
    end

    // R3..R7 command sweep over every bank A code
    for (int ca = 0; ca < 32; ca++) begin
      logic [4:0] cb;
      cb = 5'((ca * 11 + 5) & 31);
      wr(8'h10, 8'(ca * 37 + 1));
      wr(8'h11, 8'(ca * 13 + 7));
      wr(8'h12, 8'(ca * 29 + 3));
      wr(8'h13, 8'(ca * 17 + 11));
      wr(8'h00, 8'(ca * 5 + 90));
      wr(8'h01, 8'(ca * 3 + 200));
      wr(8'h02, 8'(ca * 19 + 44));
      wr(8'h03, 8'(ca * 23 + 9));
      wr(8'h14, {3'((ca * 5) & 7), 5'(ca)});   // R6 reserved bits set
      chk("R7 A latched sw_a", sw_a, ea);
      chk("R7 A latched sw_b", sw_b, eb);
      wr(8'h15, {3'((ca * 3) & 7), cb});
      chk({cls(5'(ca)), " bank A"}, sw_a, ea);
      chk({cls(cb), " bank B"}, sw_b, eb);
      chk_rd("R9 cmd A read", 8'h14, 8'h00);
      chk_rd("R9 cmd B read", 8'h15, 8'h00);
    end

    // R7 later bank A code wins; R8 B alone leaves A
    wr(8'h14, 8'd2);
    wr(8'h14, 8'd9);
    wr(8'h15, 8'd16);
    chk("R7 latest A code", sw_a, 16'h0200);
    chk("R7 B same edge", sw_b, 16'h0000);
    wr(8'h00, 8'h77);
    wr(8'h15, 8'd3);
    chk("R8 bank A held", sw_a, ea);
    chk("R8 bank B onehot", sw_b, 16'h0008);
    chk_rd("R9 unmapped", 8'h05, 8'h00);
    chk_rd("R9 unmapped", 8'h20, 8'h00);

    // R11 bulk load wins over a byte write in the same cycle
    @(negedge clk);
    bulk_valid = 1'b1; bulk_data = 32'hC3A5_1E69;
    reg_valid = 1'b1; reg_addr = 8'h10; reg_wdata = 8'hFF;
    @(negedge clk);
    bulk_valid = 1'b0; reg_valid = 1'b0;
    ea = 16'h1E69; eb = 16'hC3A5;
    chk("R11 sw_a", sw_a, ea);
    chk("R11 sw_b", sw_b, eb);
    chk_rd("R11 staging untouched", 8'h10, sa[7:0]);
    @(negedge clk);
    bulk_valid = 1'b1; bulk_data = 32'h0F0F_8001;
    reg_valid = 1'b1; reg_addr = 8'h15; reg_wdata = 8'd16;
    @(negedge clk);
    bulk_valid = 1'b0; reg_valid = 1'b0;
    chk("R11 cmd dropped A", sw_a, 16'h8001);
    chk("R11 cmd dropped B", sw_b, 16'h0F0F);
    ea = 16'h8001; eb = 16'h0F0F;

    // R10 shutdown clears and blocks writes
    wr(8'h14, 8'd5);
    @(negedge clk);
    shdn_n = 1'b0;
    @(negedge clk);
    chk("R10 sw_a cleared", sw_a, 0);
    chk("R10 sw_b cleared", sw_b, 0);
    raw_wr(8'h00, 8'hFF);
    chk("R10 write ignored", sw_a, 0);
    @(negedge clk);
    bulk_valid = 1'b1; bulk_data = 32'hFFFF_FFFF;
    @(negedge clk);
    bulk_valid = 1'b0;
    chk("R10 bulk ignored", {sw_b, sw_a}, 0);
    shdn_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++)
      chk_rd("R10 staging cleared", 8'(8'h10 + a), 8'h00);
    ea = '0; eb = '0; sa = '0; sb = '0; pa = 1'b0;
    wr(8'h00, 8'h5A);
    wr(8'h15, 8'd17);
    chk("R10 A latch cleared", sw_a, 16'h005A);
    chk("R10 B copy of cleared staging", sw_b, 16'h0000);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule